// File: doc/BRIEF.md
# Conversion Sequencer with Single-Shot and Free-Running Modes

This block paces the conversions of a sampling converter from one 16-bit configuration word. It keeps the mode selection, the rate field and a combined start/status bit. It raises a one-cycle launch pulse for each conversion and times the conversion by counting a free-running tick. At the end of each conversion it raises a one-cycle completion strobe. Logic further down the chain uses that strobe to capture the result and to run any threshold comparison.

In single-shot mode the block sits idle with its power down. A write that sets the top bit starts exactly one conversion. In free-running mode conversions follow each other with no gap. The channel-select, gain and comparator fields are not used here: the block stores them and returns them on read.

The length of a conversion is a whole number of ticks. That number is the tick frequency divided by the selected sample rate, rounded up. The tick frequency is a parameter.

Top module: `conv_sequencer`

## Requirements
- R1: After reset the configuration reads 16'h8583. `busy_o`, `conv_start_o` and `conv_done_o` are all low.
- R2: A write stores bits 14:0 and they read back unchanged. Read bit 15 returns the inverse of `busy_o`: 1 when idle, 0 while a conversion runs.
- R3: When the block is idle and bit 8 of the write is 1 (single-shot), a write with bit 15 = 1 starts one conversion. `conv_start_o` pulses in the cycle after the write and `busy_o` rises in the same cycle.
- R4: A write with bit 15 = 0 in power-down starts nothing. A write with bit 15 = 1 during a conversion adds no launch and does not lengthen the conversion.
- R5: A conversion lasts N ticks, with N = ceil(TICK_HZ / rate). Bits 7:5 select the rate in samples per second: 0→128, 1→250, 2→490, 3→920, 4→1600, 5→2400, 6 and 7→3300. `conv_done_o` is high for one cycle right after the edge that counts the Nth tick.
- R6: After a single-shot conversion completes, `busy_o` falls in the same cycle as `conv_done_o` and read bit 15 returns 1.
- R7: With bit 8 = 0 (free-running), a conversion starts as soon as the block is idle. Each completion is followed at once by a new launch, and `conv_start_o` is high in the same cycle as `conv_done_o`.
- R8: Writing bit 8 = 1 during free-running lets the current conversion finish, with exactly one more `conv_done_o`, and then the block stops.
- R9: The rate is sampled at launch. A rate change written during a conversion applies only to the next conversion.
- R10: Only cycles with `tick_i` high advance a conversion. With no ticks the block stays busy and gives no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_i | input | 1 | Time-base tick, one cycle per period |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 16 | Configuration write data |
| cfg_rdata_o | output | 16 | Configuration read value, with the busy status inverted in bit 15 |
| conv_start_o | output | 1 | One-cycle pulse at each conversion launch |
| conv_done_o | output | 1 | One-cycle pulse at each conversion completion |
| busy_o | output | 1 | High while a conversion runs |

## Verification
A single-shot conversion is run at each of the eight rate codes. This separates the counts per rate, shows that codes 6 and 7 both map to the same rate, and catches off-by-one errors in the tick count. A long conversion is held with the tick stopped, which shows that only ticks are counted. During that conversion a start write with a new rate shows both that the start is ignored and that the rate is sampled at launch. A free-running run followed by a stop write checks the back-to-back launches and that the block stops after exactly one more completion.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  // Stored configuration bits 14:0; bit 15 is status and is not stored
  typedef struct packed {
    logic [2:0] chan_sel;
    logic [2:0] gain_sel;
    logic       single_mode;
    logic [2:0] rate_sel;
    logic [4:0] cmp_bits;
  } cfg_t;

  localparam logic [14:0] CFG_RESET = 15'h0583;

  function automatic int unsigned rate_sps(logic [2:0] sel);
    case (sel)
      3'd0:    return 128;
      3'd1:    return 250;
      3'd2:    return 490;
      3'd3:    return 920;
      3'd4:    return 1600;
      3'd5:    return 2400;
      default: return 3300;
    endcase
  endfunction

  // Ticks per conversion, rounded up, at least one
  function automatic int unsigned conv_ticks(int unsigned tick_hz, logic [2:0] sel);
    int unsigned sps;
    int unsigned n;
    sps = rate_sps(sel);
    n   = (tick_hz + sps - 1) / sps;
    return (n == 0) ? 1 : n;
  endfunction

endpackage

// File: rtl/conv_seq_cfg.sv
module conv_seq_cfg
  import conv_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_i,
  input  logic [14:0] wdata_i,
  output cfg_t        cfg_q_o,
  output cfg_t        cfg_nx_o
);
  cfg_t cfg_q;

  // Value the register will hold after this edge
  assign cfg_nx_o = we_i ? cfg_t'(wdata_i) : cfg_q;
  assign cfg_q_o  = cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= cfg_t'(CFG_RESET);
    else        cfg_q <= cfg_nx_o;
  end

  // R2: a write is stored exactly as given
  a_r2_write_stored: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (cfg_q == cfg_t'($past(wdata_i))));

endmodule

// File: rtl/conv_seq_timer.sv
module conv_seq_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] tc_i,
  input  logic             run_i,
  input  logic             tick_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] tc_q;
  logic             last_tick;

  assign last_tick = (cnt_q == tc_q - CNT_W'(1));
  assign expire_o  = run_i & tick_i & last_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tc_q  <= CNT_W'(1);
    end else if (load_i) begin
      cnt_q <= '0;
      tc_q  <= (tc_i == '0) ? CNT_W'(1) : tc_i;
    end else if (run_i && tick_i) begin
      cnt_q <= last_tick ? '0 : cnt_q + CNT_W'(1);
    end
  end

  // R5: the count never passes the terminal value taken at launch
  a_r5_cnt_below_tc: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < tc_q));

  // R10: without a tick the count holds
  a_r10_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !tick_i && !load_i) |=> $stable(cnt_q));

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import conv_seq_pkg::*;
#(
  parameter int unsigned TICK_HZ = 6600
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        cfg_we_i,
  input  logic [15:0] cfg_wdata_i,
  output logic [15:0] cfg_rdata_o,
  output logic        conv_start_o,
  output logic        conv_done_o,
  output logic        busy_o
);
  localparam int unsigned MAX_TC = conv_ticks(TICK_HZ, 3'd0);
  localparam int unsigned CNT_W  = $clog2(MAX_TC + 1);

  cfg_t             cfg_q;
  cfg_t             cfg_nx;
  logic             busy_q;
  logic             expire;
  logic             conv_end;
  logic             os_req;
  logic             launch;
  logic [CNT_W-1:0] next_tc;

  conv_seq_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (cfg_we_i),
    .wdata_i  (cfg_wdata_i[14:0]),
    .cfg_q_o  (cfg_q),
    .cfg_nx_o (cfg_nx)
  );

  // Named events for the assertions
  assign os_req   = cfg_we_i & cfg_wdata_i[15];
  assign conv_end = busy_q & expire;
  assign launch   = (~busy_q & (~cfg_nx.single_mode | os_req))
                  | (conv_end & ~cfg_nx.single_mode);
  assign next_tc  = CNT_W'(conv_ticks(TICK_HZ, cfg_nx.rate_sel));

  conv_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (launch),
    .tc_i     (next_tc),
    .run_i    (busy_q),
    .tick_i   (tick_i),
    .expire_o (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q       <= 1'b0;
      conv_start_o <= 1'b0;
      conv_done_o  <= 1'b0;
    end else begin
      conv_start_o <= launch;
      conv_done_o  <= conv_end;
      if (launch)        busy_q <= 1'b1;
      else if (conv_end) busy_q <= 1'b0;
    end
  end

  assign busy_o      = busy_q;
  assign cfg_rdata_o = {~busy_q, cfg_q};

  // R3: every launch leaves the block busy
  a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |-> busy_o);

  // R4: no launch while a conversion runs and has not ended
  a_r4_no_start_midway: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !conv_end) |=> !conv_start_o);

  // R6 / R8: stopping only happens with single-shot selected
  a_r8_stop_in_single: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done_o && !busy_o) |-> cfg_q.single_mode);

  // R7: free-running completion is followed by a launch in the same cycle
  a_r7_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done_o && !cfg_q.single_mode) |-> conv_start_o);

  // R5: completion only follows a running conversion
  a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done_o |-> $past(busy_q));

endmodule

// File: tb/conv_sequencer_bench.sv
module conv_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b1;
  logic        cfg_we_i = 1'b0;
  logic [15:0] cfg_wdata_i = '0;
  logic [15:0] cfg_rdata_o;
  logic        conv_start_o;
  logic        conv_done_o;
  logic        busy_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  conv_sequencer #(.TICK_HZ(6600)) u_conv_sequencer (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .cfg_we_i     (cfg_we_i),
    .cfg_wdata_i  (cfg_wdata_i),
    .cfg_rdata_o  (cfg_rdata_o),
    .conv_start_o (conv_start_o),
    .conv_done_o  (conv_done_o),
    .busy_o       (busy_o)
  );

  // Ticks per conversion at 6600 Hz for rate codes 0..7, worked out by hand
  localparam int unsigned EXP_TC [8] = '{52, 27, 14, 8, 5, 3, 2, 2};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1;
    cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  // Count negedges until a completion is seen
  task automatic wait_done(output int n, output int starts);
    n = 0;
    starts = 0;
    while (!conv_done_o && n < 400) begin
      @(negedge clk);
      n++;
      if (conv_start_o) starts++;
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int n;
    int st;
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 rdata", cfg_rdata_o, 16'h8583);
    check("R1 busy", busy_o, 0);
    check("R1 start", conv_start_o, 0);
    check("R1 done", conv_done_o, 0);

    // Table walk: single-shot at every rate code
    for (int i = 0; i < 8; i++) begin
      logic [15:0] d;
      d = {1'b1, 3'b000, 3'b010, 1'b1, 3'(i), 5'b00011};
      wr(d);
      check("R3 start pulse", conv_start_o, 1);
      check("R3 busy", busy_o, 1);
      check("R2 os reads busy", cfg_rdata_o[15], 0);
      wait_done(n, st);
      check($sformatf("R5 ticks rate %0d", i), n, EXP_TC[i]);
      check("R6 idle at done", busy_o, 0);
      check("R6 os reads 1", cfg_rdata_o, {1'b1, d[14:0]});
      @(negedge clk);
      check("R5 done one cycle", conv_done_o, 0);
    end

    // R2 storage of non-status bits
    wr(16'h7B5C);
    check("R2 readback", cfg_rdata_o, 16'hFB5C);
    // R4 OS=0 in power-down starts nothing
    cnt = 0;
    for (int k = 0; k < 6; k++) begin
      if (conv_start_o || busy_o) cnt++;
      @(negedge clk);
    end
    check("R4 no start on os=0", cnt, 0);

    // R10 no ticks: stays busy without completion
    tick_i = 1'b0;
    wr(16'h8303);
    cnt = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (conv_done_o) cnt++;
    end
    check("R10 no done without tick", cnt, 0);
    check("R10 still busy", busy_o, 1);
    // R4 / R9 start request with new rate during conversion
    wr(16'h83C3);
    tick_i = 1'b1;
    wait_done(n, st);
    check("R4 no extra start", st, 0);
    check("R9 old rate kept", n, EXP_TC[0]);
    check("R9 new rate stored", cfg_rdata_o, 16'h83C3);
    wr(16'h83C3);
    wait_done(n, st);
    check("R9 new rate used", n, EXP_TC[6]);

    // R7 free-running at rate 6 (2 ticks)
    wr(16'h04C3);
    check("R7 launch", conv_start_o, 1);
    cnt = 0;
    st = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (conv_done_o) begin
        cnt++;
        if (conv_start_o && busy_o) st++;
      end
    end
    check("R7 done count", cnt, 10);
    check("R7 relaunch with done", st, 10);

    // R8 stop request
    wr(16'h05C3);
    cnt = conv_done_o ? 1 : 0;
    n = 0;
    while (busy_o && n < 100) begin
      @(negedge clk);
      n++;
      if (conv_done_o) cnt++;
    end
    check("R8 one more done", cnt, 1);
    check("R8 os reads idle", cfg_rdata_o, 16'h85C3);
    cnt = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (conv_start_o || busy_o) cnt++;
    end
    check("R8 stays stopped", cnt, 0);

    report();
  end
endmodule